// File: doc/BRIEF.md
# Bank Activate Rate Governor

This block sits in the command path of a DDR2 memory controller, between the bank scheduler and the command bus. Each cycle the scheduler may present one row-activate request together with a 3-bit bank number. The governor answers in the same cycle. Either it lets the request go at the coming clock edge, or it raises a stall. While the stall is high the scheduler keeps the request asserted and unchanged. One cycle after the request is taken, a registered grant pulse and the registered bank number go out toward the command bus.

Two timing limits apply, both given in picoseconds and turned into clock counts when the block is built. The first is a minimum spacing between any two activates. The second is a sliding window that lets at most four activates through, whichever banks they target and whether those banks are open or closed. The window limit is switched on only when the device has eight banks. A short history of the most recent activates, each with its age in cycles, is the only state the decision needs.

Top module: `act_rate_governor`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `act_grant` and `granted_bank` read 0 at the clock edge, and the activate history is cleared.
- R2: The first request after reset is taken at once: `act_stall` is low in that cycle.
- R3: A request is taken in a cycle where `act_req` is 1 and `act_stall` is 0. `act_grant` is high for exactly the next cycle, with `granted_bank` equal to the `act_bank` of that request. `act_grant` is never high otherwise.
- R4: Two taken requests are at least TRRD_CYC cycles apart (2 by default, from 7500 ps at 3750 ps). With continuous requests, activates land on cycles 0, 2, 4, 6.
- R5: With the window enabled, any TFAW_CYC consecutive cycles (10 by default, from 37500 ps) hold at most four taken requests. A fifth stalls until the cycle of the fourth-most-recent activate plus TFAW_CYC. Activates at 0, 2, 4, 6 put the fifth at 10. If the spacing limit is the later bound, it decides: activates at 0, 3, 6, 9 put the fifth at 11 and the sixth at 13.
- R6: Both limits count every activate whatever its bank: repeated activates to the same bank follow the same 0, 2, 4, 6, 10, 12 pattern as different banks.
- R7: `act_stall` is high only while `act_req` is high. A cycle without a request gives no grant. A request withdrawn while it was stalled is never granted.
- R8: A stalled request that is held is taken in the first cycle both limits allow. It is never dropped.
- R9: The window limit exists only when NUM_BANKS is 8. With any other bank count, only the spacing limit applies: continuous requests are taken every TRRD_CYC cycles without end.
- R10: Cycle counts are ceil(ps / TCK_PS), at least 1. For example, 4000 ps at 3750 ps gives 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_req | input | 1 | Activate request, held while stalled |
| act_bank | input | BANK_W (3) | Bank number of the request |
| act_stall | output | 1 | Request cannot be taken this cycle |
| act_grant | output | 1 | Registered pulse: an activate was issued |
| granted_bank | output | BANK_W (3) | Registered bank number of the issued activate |

## Verification
Two limits can both block the same request in the same cycle, and the interesting case is which one lets go last. The benches hold requests with spacings chosen so that the window expires on a cycle where the spacing limit still blocks (fifth activate due at 11 rather than 10). Other patterns make the window the only blocker (cycles 8 and 9 of the 0, 2, 4, 6 pattern). Each cycle's expected stall comes from a bench model that keeps the list of taken cycles. The observed grant cycles are also compared with the fixed cycle lists given in the requirements.

// File: rtl/act_gov_pkg.sv
// Package: shared constants and helpers for the activate rate governor.
// Assumes timing values in picoseconds and a clock period in picoseconds.
package act_gov_pkg;

    // Activates allowed inside one rolling window
    localparam int DEF_WIN_ACTS = 4;

    // Bank count at which the rolling window applies
    localparam int WINDOW_BANKS = 8;

    // Convert a time in ps to a clock count, rounded up, floor of 1
    function automatic int ps_to_cycles(input int t_ps, input int tck_ps);
        int c;
        c = (t_ps + tck_ps - 1) / tck_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/act_history.sv
// Module: act_history
// Keeps the ages (cycles since issue) of the last WIN_ACTS activates, entry 0
// being the newest. Ages saturate at AGE_MAX, which must be at least as large
// as every limit they are compared against. Assumes push is the issue strobe.
module act_history #(
    parameter int WIN_ACTS = 4,
    parameter int AGE_MAX  = 10,
    parameter int AGE_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    output logic             newest_valid,
    output logic [AGE_W-1:0] newest_age,
    output logic             full,
    output logic [AGE_W-1:0] oldest_age
);

    logic             vld_q [WIN_ACTS];
    logic [AGE_W-1:0] age_q [WIN_ACTS];

    // Saturating age step
    function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] a);
        return (a >= AGE_W'(AGE_MAX)) ? a : a + 1'b1;
    endfunction

    for (genvar i = 0; i < WIN_ACTS; i++) begin : g_entry
        if (i == 0) begin : g_head
            // Newest slot: loaded on issue, otherwise ages
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[0] <= 1'b0;
                    age_q[0] <= '0;
                end else if (push) begin
                    vld_q[0] <= 1'b1;
                    age_q[0] <= AGE_W'(1);
                end else if (vld_q[0]) begin
                    age_q[0] <= age_step(age_q[0]);
                end
            end
        end else begin : g_tail
            // Older slots: shift from the younger neighbour on issue, otherwise age
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[i] <= 1'b0;
                    age_q[i] <= '0;
                end else if (push) begin
                    vld_q[i] <= vld_q[i-1];
                    age_q[i] <= age_step(age_q[i-1]);
                end else if (vld_q[i]) begin
                    age_q[i] <= age_step(age_q[i]);
                end
            end

            // R5: history fills from the newest end and ages never decrease toward the oldest
            hist_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q[i] |-> (vld_q[i-1] && (age_q[i] >= age_q[i-1])));
        end
    end

    assign newest_valid = vld_q[0];
    assign newest_age   = age_q[0];
    assign full         = vld_q[WIN_ACTS-1];
    assign oldest_age   = age_q[WIN_ACTS-1];

endmodule

// File: rtl/act_window_check.sv
// Module: act_window_check
// Combinational test of the two limits against the history. The window test
// is generated only when FAW_EN is set; otherwise it always passes.
module act_window_check #(
    parameter int TRRD_CYC = 2,
    parameter int TFAW_CYC = 10,
    parameter bit FAW_EN   = 1'b1,
    parameter int AGE_W    = 4
) (
    input  logic             newest_valid,
    input  logic [AGE_W-1:0] newest_age,
    input  logic             full,
    input  logic [AGE_W-1:0] oldest_age,
    output logic             rrd_ok,
    output logic             faw_ok
);

    // Spacing: no prior activate, or the newest is old enough
    assign rrd_ok = !newest_valid || (newest_age >= AGE_W'(TRRD_CYC));

    if (FAW_EN) begin : g_faw
        // Window: fewer than WIN_ACTS recorded, or the oldest has left the window
        assign faw_ok = !full || (oldest_age >= AGE_W'(TFAW_CYC));
    end else begin : g_no_faw
        logic unused_w;
        assign unused_w = full ^ (^oldest_age);
        assign faw_ok   = 1'b1;
    end

endmodule

// File: rtl/act_issue_reg.sv
// Module: act_issue_reg
// Output register for the issued activate: a one-cycle grant pulse and the
// bank number, which holds its last value between grants.
module act_issue_reg #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BANK_W-1:0] take_bank,
    output logic              grant_q,
    output logic [BANK_W-1:0] bank_q
);

    // Register the grant strobe and bank of the taken request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            bank_q  <= '0;
        end else begin
            grant_q <= take;
            if (take) begin
                bank_q <= take_bank;
            end
        end
    end

endmodule

// File: rtl/act_rate_governor.sv
// Module: act_rate_governor (top)
// Decides each cycle whether a held activate request may issue under the
// spacing and rolling-window limits. Assumes the requester keeps act_req and
// act_bank stable while act_stall is high. Cycle counts come from ps values.
module act_rate_governor
    import act_gov_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int TCK_PS    = 3750,
    parameter int TRRD_PS   = 7500,
    parameter int TFAW_PS   = 37500,
    parameter int WIN_ACTS  = DEF_WIN_ACTS,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_req,
    input  logic [BANK_W-1:0] act_bank,
    output logic              act_stall,
    output logic              act_grant,
    output logic [BANK_W-1:0] granted_bank
);

    localparam int TRRD_CYC = ps_to_cycles(TRRD_PS, TCK_PS);
    localparam int TFAW_CYC = ps_to_cycles(TFAW_PS, TCK_PS);
    localparam bit FAW_EN   = (NUM_BANKS == WINDOW_BANKS);
    localparam int AGE_MAX  = (TFAW_CYC > TRRD_CYC) ? TFAW_CYC : TRRD_CYC;
    localparam int AGE_W    = $clog2(AGE_MAX + 1);

    logic             newest_valid, full, rrd_ok, faw_ok, take;
    logic [AGE_W-1:0] newest_age, oldest_age;

    act_history #(
        .WIN_ACTS(WIN_ACTS), .AGE_MAX(AGE_MAX), .AGE_W(AGE_W)
    ) hist_i (
        .clk(clk), .rst_n(rst_n), .push(take),
        .newest_valid(newest_valid), .newest_age(newest_age),
        .full(full), .oldest_age(oldest_age)
    );

    act_window_check #(
        .TRRD_CYC(TRRD_CYC), .TFAW_CYC(TFAW_CYC), .FAW_EN(FAW_EN), .AGE_W(AGE_W)
    ) chk_i (
        .newest_valid(newest_valid), .newest_age(newest_age),
        .full(full), .oldest_age(oldest_age),
        .rrd_ok(rrd_ok), .faw_ok(faw_ok)
    );

    // Take the request when both limits pass; otherwise stall it
    assign take      = act_req && rrd_ok && faw_ok;
    assign act_stall = act_req && !(rrd_ok && faw_ok);

    act_issue_reg #(.BANK_W(BANK_W)) out_i (
        .clk(clk), .rst_n(rst_n), .take(take), .take_bank(act_bank),
        .grant_q(act_grant), .bank_q(granted_bank)
    );

    // ---------------- checker state, driven from the ports only ----------------
    logic [31:0] cyc_q;
    logic [31:0] gap_q;
    logic        any_grant_q;
    logic [31:0] stamp_q [WIN_ACTS];
    logic [31:0] seen_q;

    // Free-running cycle count and spacing since the last grant pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q       <= '0;
            gap_q       <= '0;
            any_grant_q <= 1'b0;
            seen_q      <= '0;
        end else begin
            cyc_q <= cyc_q + 1;
            if (act_grant) begin
                gap_q       <= 32'd1;
                any_grant_q <= 1'b1;
                if (seen_q < 32'(WIN_ACTS)) seen_q <= seen_q + 1;
            end else if (gap_q < 32'(AGE_MAX)) begin
                gap_q <= gap_q + 1;
            end
        end
    end

    // Shift register of the cycles on which grant pulses were seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WIN_ACTS; k++) stamp_q[k] <= '0;
        end else if (act_grant) begin
            stamp_q[0] <= cyc_q;
            for (int k = 1; k < WIN_ACTS; k++) stamp_q[k] <= stamp_q[k-1];
        end
    end

    // R3: a grant follows exactly one cycle after a taken request, with its bank
    grant_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_grant |-> ($past(act_req && !act_stall) && (granted_bank == $past(act_bank))));

    // R2: the first request after reset is never stalled
    first_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && act_req) |-> !act_stall);

    // R7: stall only accompanies a request
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_stall |-> act_req);

    // R4: grant pulses keep the minimum spacing
    rrd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_grant && any_grant_q) |-> (gap_q >= 32'(TRRD_CYC)));

    if (FAW_EN) begin : g_faw_chk
        // R5: the WIN_ACTS-th previous grant lies at least TFAW_CYC cycles back
        faw_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_grant && (seen_q >= 32'(WIN_ACTS))) |->
                ((cyc_q - stamp_q[WIN_ACTS-1]) >= 32'(TFAW_CYC)));
    end

endmodule

// File: tb/act_rate_governor_tb_top.sv
// Directed bench for act_rate_governor: an eight-bank instance (window on)
// and a four-bank instance (window off, spacing from 4000 ps).
module act_rate_governor_tb_top;

    localparam int TRRD  = 2;
    localparam int TFAW  = 10;
    localparam int TRRD4 = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, req4 = 1'b0;
    logic [2:0] bank = '0;
    logic [1:0] bank4 = '0;
    logic       stall, grant, stall4, grant4;
    logic [2:0] gbank;
    logic [1:0] gbank4;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Bench model: cycles on which requests were taken, per instance
    int hist0[$];
    int hist4[$];
    bit prev_take0 = 1'b0, prev_take4 = 1'b0;
    int prev_bank0 = 0, prev_bank4 = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    act_rate_governor dut_i (
        .clk(clk), .rst_n(rst_n), .act_req(req), .act_bank(bank),
        .act_stall(stall), .act_grant(grant), .granted_bank(gbank)
    );

    act_rate_governor #(.NUM_BANKS(4), .TRRD_PS(4000)) dut4_i (
        .clk(clk), .rst_n(rst_n), .act_req(req4), .act_bank(bank4),
        .act_stall(stall4), .act_grant(grant4), .granted_bank(gbank4)
    );

    task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act_v, exp_v, cyc);
        end
    endtask

    function automatic bit allowed0(input int c);
        int n = hist0.size();
        if (n > 0 && (c - hist0[n-1]) < TRRD) return 1'b0;
        if (n >= 4 && (c - hist0[n-4]) < TFAW) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit allowed4(input int c);
        int n = hist4.size();
        return !(n > 0 && (c - hist4[n-1]) < TRRD4);
    endfunction

    // One cycle on either instance: drive at the falling edge, check, advance
    task automatic step(input bit sel4, input bit r, input int b, input string tag, output bit took);
        bit exp_stall;
        int c;
        if (!sel4) begin req = r; bank = 3'(b); end
        else begin req4 = r; bank4 = 2'(b); end
        #1;
        c = cyc;
        if (!sel4) begin
            check(grant == prev_take0, {tag, " R3 grant"}, grant, prev_take0);
            if (prev_take0) check(gbank == 3'(prev_bank0), {tag, " R3 bank"}, gbank, prev_bank0);
            exp_stall = r && !allowed0(c);
            check(stall == exp_stall, {tag, " R7 stall"}, stall, exp_stall);
            took = r && !exp_stall;
            prev_take0 = took; prev_bank0 = b;
            if (took) hist0.push_back(c);
        end else begin
            check(grant4 == prev_take4, {tag, " R9 grant"}, grant4, prev_take4);
            if (prev_take4) check(gbank4 == 2'(prev_bank4), {tag, " R9 bank"}, gbank4, prev_bank4);
            exp_stall = r && !allowed4(c);
            check(stall4 == exp_stall, {tag, " R10 stall"}, stall4, exp_stall);
            took = r && !exp_stall;
            prev_take4 = took; prev_bank4 = b;
            if (took) hist4.push_back(c);
        end
        @(negedge clk);
    endtask

    // Hold a request until it is taken; return the cycle it was taken on
    task automatic hold_req(input bit sel4, input int b, input string tag, output int at);
        bit took = 1'b0;
        int guard = 0;
        while (!took && guard < 40) begin
            at = cyc;
            step(sel4, 1'b1, b, tag, took);
            guard++;
        end
    endtask

    task automatic idle(input bit sel4, input int n);
        bit t;
        for (int i = 0; i < n; i++) step(sel4, 1'b0, 0, "idle", t);
    endtask

    task automatic t_reset;
        req = 1'b1; bank = 3'd5; req4 = 1'b1; bank4 = 2'd2;
        repeat (3) @(negedge clk);
        // R1: outputs clear while reset is held, even with a request present
        check(grant == 1'b0, "R1 grant in reset", grant, 0);
        check(gbank == 3'd0, "R1 bank in reset", gbank, 0);
        check(grant4 == 1'b0, "R1 grant4 in reset", grant4, 0);
        req = 1'b0; req4 = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_first;
        int at;
        // R2: the first request is taken in its own cycle
        hold_req(1'b0, 3, "R2 first", at);
        check(hist0.size() == 1 && hist0[0] == at, "R2 first taken at once", hist0.size(), 1);
        idle(1'b0, 1);
    endtask

    task automatic t_burst(input bit same_bank, input string tag);
        int base, at;
        int exp_off[6] = '{0, 2, 4, 6, 10, 12};
        idle(1'b0, TFAW + 2);
        for (int k = 0; k < 6; k++) begin
            hold_req(1'b0, same_bank ? 7 : k, tag, at);
            if (k == 0) base = at;
            // R4 R5 R6 R8: held requests land on the listed cycles
            check((at - base) == exp_off[k], {tag, " R5 offset"}, at - base, exp_off[k]);
        end
        idle(1'b0, 1);
    endtask

    task automatic t_rrd_binds;
        int base, at;
        int exp_off[6] = '{0, 3, 6, 9, 11, 13};
        idle(1'b0, TFAW + 2);
        for (int k = 0; k < 6; k++) begin
            if (k > 0 && k < 4) idle(1'b0, 2);
            hold_req(1'b0, k + 1, "R4 R5 rrd-after-faw", at);
            if (k == 0) base = at;
            check((at - base) == exp_off[k], "R4 spacing binds after window", at - base, exp_off[k]);
        end
        idle(1'b0, 1);
    endtask

    task automatic t_withdraw;
        int at;
        bit t;
        idle(1'b0, TFAW + 2);
        hold_req(1'b0, 2, "R7 setup", at);
        // Next cycle is stalled by spacing; withdraw the request there
        step(1'b0, 1'b1, 6, "R7 stalled", t);
        check(t == 1'b0, "R7 request stalled", t, 0);
        step(1'b0, 1'b0, 6, "R7 withdrawn", t);
        idle(1'b0, 3);
        check(hist0.size() > 0 && hist0[hist0.size()-1] == at, "R7 withdrawn not granted", hist0[hist0.size()-1], at);
    endtask

    task automatic t_no_window;
        int base, at;
        // R9 R10: four banks, no window, 4000 ps -> 2 cycles
        for (int k = 0; k < 7; k++) begin
            hold_req(1'b1, k % 4, "R9 no window", at);
            if (k == 0) base = at;
            check((at - base) == 2 * k, "R9 R10 steady spacing", at - base, 2 * k);
        end
        idle(1'b1, 2);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_first();
        t_burst(1'b0, "R5 burst");
        t_burst(1'b1, "R6 same bank");
        t_rrd_binds();
        t_withdraw();
        t_no_window();
        done = 1'b1;
        report();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
        end
    end

endmodule